// File: doc/BRIEF.md
# SPI Pixel Command Decoder

This block sits behind the SPI pins of a pixel-strip controller. A master frames each transaction with chip select. The first byte of a frame is a command. Depending on the command, an address byte, a dummy byte or both may follow, and then one or more data bytes. The decoder answers identification queries and reads and writes a simple byte-wide register port. It also turns four load commands into tagged words that it pushes into a pixel FIFO.

While a load command runs, every byte the master clocks out of MISO carries the status byte that the register block presents at that moment. The master can use it for flow control. RGB loads pack three bytes per word and WRGB loads pack four. Each byte of a reset-cycle or reset-code load inserts one reset word, whatever its value. A built-in mode-0 shift register oversamples SCLK, CSN and MOSI with the system clock. The FIFO storage and the LED serializer live outside this block.

Top module: `spi_pixel_cmd`

## Requirements
- R1: Command 0xF0 is followed by one dummy byte, and the next byte on MISO is the parameter HW_ID. Command 0xF1 behaves the same way but returns REV_ID.
- R2: Command 0x00 takes an address byte and then a dummy byte. Each later byte on MISO is the register at the current address, and the address steps by one after each of these data bytes.
- R3: Command 0x01 takes an address byte, with no dummy byte. Each later byte gives one reg_wr_o pulse, with reg_wdata_o equal to that byte and reg_addr_o starting at the given address and stepping by one for each byte.
- R4: During commands 0x04 to 0x07, each byte after the command byte returns on MISO the value of status_i taken at the end of the previous byte, so a change in status_i shows up in the next byte loaded.
- R5: Command 0x04 packs each three bytes into one push. The word has tag 2'b00 in bits 33:32 and payload {8'h00, first, second, third} in bits 31:0.
- R6: Command 0x05 packs each four bytes into one push, with tag 2'b01 and payload {first, second, third, fourth}.
- R7: Each byte of command 0x06 pushes one word with tag 2'b10, and each byte of 0x07 pushes one word with tag 2'b11. The payload is zero in both cases, whatever the byte value.
- R8: Raising CSN drops any partially packed word, and the next frame starts with a command byte.
- R9: When a word completes while fifo_full_i is high, no push happens and overflow_o pulses for exactly one cycle.
- R10: An undefined command byte causes no register write and no push, and MISO returns 0x00 for the rest of the frame.
- R11: After reset, MISO is low and neither reg_wr_o nor fifo_push_o is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI clock from master (mode 0) |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from master, MSB first |
| miso_o | output | 1 | SPI data to master, MSB first |
| reg_addr_o | output | ADDR_W | Register address for read and write |
| reg_wr_o | output | 1 | Register write strobe, one cycle per byte |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |
| status_i | input | 8 | Status byte returned during loads |
| fifo_push_o | output | 1 | FIFO write strobe |
| fifo_word_o | output | PAYLOAD_W+2 | Tag in the top two bits, payload below |
| fifo_full_i | input | 1 | FIFO cannot accept a word |
| overflow_o | output | 1 | One-cycle pulse when a word is dropped |

## Verification
A completed word and a full FIFO can land in the same cycle. The decoder must then choose between pushing the word and reporting an overflow. The bench raises fifo_full_i before an RGB frame and lets the third byte complete a word. It then checks that the scoreboard sees no push and that exactly one single-cycle overflow pulse is counted. The MISO bytes of that frame must still carry the status value, so status echo and overflow are judged together.

// File: rtl/spix_pkg.sv
package spix_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_ID     = 8'hF0;
  localparam logic [7:0] CMD_REV    = 8'hF1;
  localparam logic [7:0] CMD_RD     = 8'h00;
  localparam logic [7:0] CMD_WR     = 8'h01;
  localparam logic [7:0] CMD_LD_RGB = 8'h04;
  localparam logic [7:0] CMD_LD_CD  = 8'h07;

  typedef enum logic [1:0] {
    TAG_RGB  = 2'b00,
    TAG_WRGB = 2'b01,
    TAG_RCYC = 2'b10,
    TAG_RCOD = 2'b11
  } tag_e;

  typedef enum logic [3:0] {
    ST_CMD, ST_ID_DUMMY, ST_ID_DATA, ST_RD_ADDR, ST_RD_DUMMY,
    ST_RD_DATA, ST_WR_ADDR, ST_WR_DATA, ST_LOAD, ST_IGNORE
  } dec_state_e;
endpackage

// File: rtl/spix_spi_shifter.sv
module spix_spi_shifter
  import spix_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              miso_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              idle_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sclk_sync, csn_sync, mosi_sync;
  logic sclk_d, csn_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_shift, tx_shift;

  wire sclk_s = sclk_sync[SYNC_STAGES-1];
  wire csn_s  = csn_sync[SYNC_STAGES-1];
  wire mosi_s = mosi_sync[SYNC_STAGES-1];
  wire sclk_rise = sclk_s & ~sclk_d;
  wire sclk_fall = ~sclk_s & sclk_d;
  wire [BYTE_W-1:0] rx_next = {rx_shift[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sync  <= '0;
      csn_sync   <= '1;
      mosi_sync  <= '0;
      sclk_d     <= 1'b0;
      csn_d      <= 1'b1;
      bit_cnt    <= '0;
      rx_shift   <= '0;
      tx_shift   <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      sclk_sync  <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      csn_sync   <= {csn_sync[SYNC_STAGES-2:0], csn_i};
      mosi_sync  <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      sclk_d     <= sclk_s;
      csn_d      <= csn_s;
      rx_valid_o <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
      end else begin
        // first MISO bit must be ready before the first rising edge
        if (csn_d) tx_shift <= tx_byte_i;
        else if (sclk_fall)
          tx_shift <= (bit_cnt == '0) ? tx_byte_i : {tx_shift[BYTE_W-2:0], 1'b0};
        if (sclk_rise) begin
          rx_shift <= rx_next;
          bit_cnt  <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W-1)) begin
            rx_valid_o <= 1'b1;
            rx_byte_o  <= rx_next;
          end
        end
      end
    end
  end

  assign miso_o = tx_shift[BYTE_W-1];
  assign idle_o = csn_s;

  p_idle_clears_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> (bit_cnt == '0));
  p_rx_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/spix_cmd_fsm.sv
module spix_cmd_fsm
  import spix_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  HW_ID  = 8'hA7,
  parameter logic [7:0]  REV_ID = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              load_valid_o,
  output tag_e              load_tag_o
);
  dec_state_e state;
  logic       id_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_CMD;
      id_sel     <= 1'b0;
      reg_addr_o <= '0;
      load_tag_o <= TAG_RGB;
    end else if (idle_i) begin
      state <= ST_CMD;
    end else if (byte_valid_i) begin
      unique case (state)
        ST_CMD: begin
          if (byte_i == CMD_ID || byte_i == CMD_REV) begin
            state  <= ST_ID_DUMMY;
            id_sel <= byte_i[0];
          end else if (byte_i == CMD_RD) begin
            state <= ST_RD_ADDR;
          end else if (byte_i == CMD_WR) begin
            state <= ST_WR_ADDR;
          end else if (byte_i >= CMD_LD_RGB && byte_i <= CMD_LD_CD) begin
            state      <= ST_LOAD;
            load_tag_o <= tag_e'(byte_i[1:0]);
          end else begin
            state <= ST_IGNORE;
          end
        end
        ST_ID_DUMMY: state <= ST_ID_DATA;
        ST_ID_DATA:  state <= ST_IGNORE;
        ST_RD_ADDR: begin
          reg_addr_o <= byte_i[ADDR_W-1:0];
          state      <= ST_RD_DUMMY;
        end
        ST_RD_DUMMY: state <= ST_RD_DATA;
        ST_RD_DATA:  reg_addr_o <= reg_addr_o + 1'b1;
        ST_WR_ADDR: begin
          reg_addr_o <= byte_i[ADDR_W-1:0];
          state      <= ST_WR_DATA;
        end
        ST_WR_DATA:  reg_addr_o <= reg_addr_o + 1'b1;
        default:     state <= state;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_ID_DATA: tx_byte_o = id_sel ? REV_ID : HW_ID;
      ST_RD_DATA: tx_byte_o = reg_rdata_i;
      ST_LOAD:    tx_byte_o = status_i;
      default:    tx_byte_o = '0;
    endcase
  end

  assign reg_wr_o     = byte_valid_i && (state == ST_WR_DATA);
  assign reg_wdata_o  = byte_i;
  assign load_valid_o = byte_valid_i && (state == ST_LOAD);

  p_wr_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !idle_i);
  p_wr_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> (reg_addr_o == $past(reg_addr_o) + 1'b1));
endmodule

// File: rtl/spix_word_packer.sv
module spix_word_packer
  import spix_pkg::*;
#(
  parameter int PAYLOAD_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 byte_valid_i,
  input  logic [BYTE_W-1:0]    byte_i,
  input  tag_e                 tag_i,
  input  logic                 fifo_full_i,
  output logic                 push_o,
  output logic [PAYLOAD_W+1:0] word_o,
  output logic                 overflow_o
);
  localparam int BYTES = PAYLOAD_W / BYTE_W;
  localparam int CNT_W = $clog2(BYTES);
  localparam int RGB_W = 3 * BYTE_W;

  logic [PAYLOAD_W-1:0] acc;
  logic [CNT_W-1:0]     cnt;
  logic                 req_q;

  wire [PAYLOAD_W-1:0] acc_next = {acc[PAYLOAD_W-BYTE_W-1:0], byte_i};
  wire [CNT_W-1:0]     last_idx = (tag_i == TAG_WRGB) ? CNT_W'(BYTES-1) : CNT_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc    <= '0;
      cnt    <= '0;
      req_q  <= 1'b0;
      word_o <= '0;
    end else begin
      req_q <= 1'b0;
      if (clear_i) begin
        cnt <= '0;
      end else if (byte_valid_i) begin
        if (tag_i[1]) begin
          word_o <= {tag_i, {PAYLOAD_W{1'b0}}};
          req_q  <= 1'b1;
          cnt    <= '0;
        end else if (cnt == last_idx) begin
          word_o <= (tag_i == TAG_WRGB) ? {tag_i, acc_next}
                  : {tag_i, {(PAYLOAD_W-RGB_W){1'b0}}, acc_next[RGB_W-1:0]};
          req_q  <= 1'b1;
          cnt    <= '0;
        end else begin
          acc <= acc_next;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign push_o     = req_q & ~fifo_full_i;
  assign overflow_o = req_q & fifo_full_i;

  p_reset_word_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && word_o[PAYLOAD_W+1]) |-> (word_o[PAYLOAD_W-1:0] == '0));
  p_push_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
  p_ovf_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> !overflow_o);
endmodule

// File: rtl/spi_pixel_cmd.sv
module spi_pixel_cmd
  import spix_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAYLOAD_W   = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] HW_ID       = 8'hA7,
  parameter logic [7:0] REV_ID      = 8'h03
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 csn_i,
  input  logic                 mosi_i,
  output logic                 miso_o,
  output logic [ADDR_W-1:0]    reg_addr_o,
  output logic                 reg_wr_o,
  output logic [7:0]           reg_wdata_o,
  input  logic [7:0]           reg_rdata_i,
  input  logic [7:0]           status_i,
  output logic                 fifo_push_o,
  output logic [PAYLOAD_W+1:0] fifo_word_o,
  input  logic                 fifo_full_i,
  output logic                 overflow_o
);
  logic              idle, rx_valid, load_valid;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  tag_e              load_tag;

  spix_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) i_shifter (
    .clk_i, .rst_ni, .sclk_i, .csn_i, .mosi_i,
    .tx_byte_i (tx_byte),
    .miso_o,
    .rx_valid_o(rx_valid),
    .rx_byte_o (rx_byte),
    .idle_o    (idle)
  );

  spix_cmd_fsm #(.ADDR_W(ADDR_W), .HW_ID(HW_ID), .REV_ID(REV_ID)) i_fsm (
    .clk_i, .rst_ni,
    .idle_i      (idle),
    .byte_valid_i(rx_valid),
    .byte_i      (rx_byte),
    .reg_rdata_i,
    .status_i,
    .tx_byte_o   (tx_byte),
    .reg_addr_o,
    .reg_wr_o,
    .reg_wdata_o,
    .load_valid_o(load_valid),
    .load_tag_o  (load_tag)
  );

  spix_word_packer #(.PAYLOAD_W(PAYLOAD_W)) i_packer (
    .clk_i, .rst_ni,
    .clear_i     (idle),
    .byte_valid_i(load_valid),
    .byte_i      (rx_byte),
    .tag_i       (load_tag),
    .fifo_full_i,
    .push_o      (fifo_push_o),
    .word_o      (fifo_word_o),
    .overflow_o
  );

  p_no_wr_and_push_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && fifo_push_o));
endmodule

// File: tb/test_spi_pixel_cmd.sv
module test_spi_pixel_cmd;
  localparam int HALF = 5;
  localparam logic [7:0] HW = 8'hA7, RV = 8'h03;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, csn = 1, mosi = 0, miso;
  logic [7:0] reg_addr, reg_wdata, reg_rdata, status = 8'h00;
  logic reg_wr, push, full = 0, ovf;
  logic [33:0] word;
  logic [7:0] regs [256];

  int n_chk = 0, n_fail = 0, ovf_seen = 0;
  bit done = 0;
  logic [33:0] exp_push[$];
  logic [15:0] exp_wr[$];

  always #2.5 clk = ~clk;
  assign reg_rdata = regs[reg_addr];

  spi_pixel_cmd i_spi_pixel_cmd (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .reg_rdata_i(reg_rdata), .status_i(status), .fifo_push_o(push),
    .fifo_word_o(word), .fifo_full_i(full), .overflow_o(ovf)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (push) begin
      if (exp_push.size() == 0) check(0, "R10 unexpected push", 64'(word), 0);
      else begin
        logic [33:0] e;
        e = exp_push.pop_front();
        check(word == e, "R5 R6 R7 pushed word", 64'(word), 64'(e));
      end
    end
    if (reg_wr) begin
      if (exp_wr.size() == 0) check(0, "R10 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = exp_wr.pop_front();
        check({reg_addr, reg_wdata} == e, "R3 register write", {reg_addr, reg_wdata}, e);
      end
      regs[reg_addr] = reg_wdata;
    end
    if (ovf) ovf_seen++;
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_start();
    csn = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    csn = 1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 256; i++) regs[i] = 8'(i) ^ 8'h5A;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(miso == 0 && !push && !reg_wr, "R11 reset outputs", {miso, push, reg_wr}, 0);

    // R1 hardware id and revision
    cs_start(); xfer(8'hF0, rx); xfer(8'h00, rx); xfer(8'h00, rx); cs_end();
    check(rx == HW, "R1 hardware id", rx, HW);
    cs_start(); xfer(8'hF1, rx); xfer(8'h00, rx); xfer(8'h00, rx); cs_end();
    check(rx == RV, "R1 revision", rx, RV);

    // R3 write burst with auto increment
    exp_wr.push_back({8'h10, 8'h11});
    exp_wr.push_back({8'h11, 8'h22});
    exp_wr.push_back({8'h12, 8'h33});
    cs_start(); xfer(8'h01, rx); xfer(8'h10, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx); cs_end();
    check(exp_wr.size() == 0, "R3 all writes seen", exp_wr.size(), 0);

    // R2 read burst with auto increment
    cs_start(); xfer(8'h00, rx); xfer(8'h10, rx); xfer(8'h00, rx);
    xfer(8'h00, rx); check(rx == 8'h11, "R2 read first", rx, 8'h11);
    xfer(8'h00, rx); check(rx == 8'h22, "R2 read second", rx, 8'h22);
    xfer(8'h00, rx); check(rx == 8'h33, "R2 read third", rx, 8'h33);
    xfer(8'h00, rx); check(rx == (8'h13 ^ 8'h5A), "R2 read fourth", rx, 8'h13 ^ 8'h5A);
    cs_end();

    // R5 RGB, R4 live status echo
    status = 8'h3C;
    exp_push.push_back({2'b00, 8'h00, 24'h123456});
    exp_push.push_back({2'b00, 8'h00, 24'hABCDEF});
    cs_start(); xfer(8'h04, rx);
    xfer(8'h12, rx); check(rx == 8'h3C, "R4 status byte1", rx, 8'h3C);
    xfer(8'h34, rx); check(rx == 8'h3C, "R4 status byte2", rx, 8'h3C);
    status = 8'hC3;
    xfer(8'h56, rx); check(rx == 8'h3C, "R4 status byte3 old", rx, 8'h3C);
    xfer(8'hAB, rx); check(rx == 8'hC3, "R4 status byte4 new", rx, 8'hC3);
    xfer(8'hCD, rx); xfer(8'hEF, rx); cs_end();
    check(exp_push.size() == 0, "R5 rgb words seen", exp_push.size(), 0);

    // R6 WRGB
    exp_push.push_back({2'b01, 32'hDEADBEEF});
    cs_start(); xfer(8'h05, rx);
    xfer(8'hDE, rx); xfer(8'hAD, rx); xfer(8'hBE, rx); xfer(8'hEF, rx); cs_end();
    check(exp_push.size() == 0, "R6 wrgb word seen", exp_push.size(), 0);

    // R7 reset cycle and reset code, data ignored
    for (int k = 0; k < 3; k++) exp_push.push_back({2'b10, 32'h0});
    cs_start(); xfer(8'h06, rx); xfer(8'hFF, rx); xfer(8'h81, rx); xfer(8'h00, rx); cs_end();
    for (int k = 0; k < 2; k++) exp_push.push_back({2'b11, 32'h0});
    cs_start(); xfer(8'h07, rx); xfer(8'h77, rx); xfer(8'hA5, rx); cs_end();
    check(exp_push.size() == 0, "R7 reset words seen", exp_push.size(), 0);

    // R8 abort partial word
    cs_start(); xfer(8'h04, rx); xfer(8'h99, rx); xfer(8'h88, rx); cs_end();
    exp_push.push_back({2'b00, 8'h00, 24'h010203});
    cs_start(); xfer(8'h04, rx); xfer(8'h01, rx); xfer(8'h02, rx); xfer(8'h03, rx); cs_end();
    check(exp_push.size() == 0, "R8 only fresh word pushed", exp_push.size(), 0);

    // R9 full drops word and pulses overflow once, status still echoed
    full = 1; status = 8'h08;
    cs_start(); xfer(8'h04, rx); xfer(8'h44, rx); xfer(8'h55, rx);
    xfer(8'h66, rx); check(rx == 8'h08, "R4 status during full", rx, 8'h08);
    cs_end();
    check(ovf_seen == 1, "R9 overflow pulse count", ovf_seen, 1);
    full = 0;

    // R10 undefined command
    cs_start(); xfer(8'h55, rx);
    xfer(8'h04, rx); check(rx == 8'h00, "R10 miso zero", rx, 0);
    xfer(8'h01, rx); xfer(8'h02, rx); check(rx == 8'h00, "R10 miso zero late", rx, 0);
    cs_end();
    check(exp_push.size() == 0 && exp_wr.size() == 0, "R10 queues empty", exp_push.size(), 0);
    check(ovf_seen == 1, "R9 no extra overflow", ovf_seen, 1);

    finish_run();
  end
endmodule